// File: doc/BRIEF.md
# Double-Buffered Two-Compare PWM Timer

This block is a 16-bit up-counting timer whose pulse-width modulation mode shapes one output pin from two compare values. The period compare ends each cycle of the waveform. When the counter matches it, the pin takes the period level and the counter restarts at 0xFFFC. The pulse compare marks the edge inside the period. When the counter matches it, the pin takes the pulse level. A one-cycle tick input paces the counter. Compares are evaluated only on ticks.

Software writes each 16-bit compare value as two bytes over an 8-bit write port. The bytes go into staging registers. Matching always uses a separate shadow copy. Each shadow is loaded from its staging register only on the period-end match, so a new setting never cuts a period short or makes a glitch. After a high byte is written, the transfer for that compare is held off until its low byte is also written. This stops a half-updated value from reaching the comparator.

Top module: `dcpwm_timer`

## Requirements
- R1: After reset the count is 0xFFFC, `pwm_o` is low, all staging and shadow compare values are zero and no compare is locked.
- R2: The count changes only on cycles where `tick_i` is high. With `tick_i` low it holds.
- R3: PWM mode is active when both `pwm_en_i` and `out_en_i` are 1. In PWM mode, a tick on which the count equals the period shadow drives `pwm_o` to `lvl_period_i` at the next edge and reloads the count to 0xFFFC.
- R4: In PWM mode, a tick on which the count equals the pulse shadow, and not the period shadow, drives `pwm_o` to `lvl_pulse_i`. The count still advances by one.
- R5: When both shadows equal the count on the same tick, the period action of R3 applies: the pin takes `lvl_period_i` and the count reloads.
- R6: Write address encoding on `wr_addr_i` is: 0 for the pulse high byte, 1 for the pulse low byte, 2 for the period high byte and 3 for the period low byte. A write changes only the staging register. Every shadow is copied from its staging register on the period-end tick and at no other time.
- R7: A high-byte write locks its compare. A low-byte write to the same compare unlocks it. A compare that is locked at the period-end tick keeps its old shadow.
- R8: When PWM mode is inactive, `pwm_o` is low from the next cycle on. The count advances by one per tick, wraps from 0xFFFF to 0x0000 and never reloads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Count enable, one cycle per timer tick |
| wr_en_i | input | 1 | Byte write strobe |
| wr_addr_i | input | 2 | Byte select (encoding in R6) |
| wr_data_i | input | 8 | Byte to write |
| pwm_en_i | input | 1 | PWM mode select |
| out_en_i | input | 1 | Output pin enable |
| lvl_pulse_i | input | 1 | Pin level after a pulse compare match |
| lvl_period_i | input | 1 | Pin level after a period compare match |
| count_o | output | 16 | Current counter value |
| pwm_o | output | 1 | PWM output pin |

## Verification
Every result of this block is registered once. A tick, a byte write or a change of mode that is present at a rising edge shows on `count_o`, `pwm_o` and in the shadows right after that edge. A new compare value therefore first affects matching on the tick after the period-end edge that loaded it. The driver applies stimulus shortly after a rising edge. At the capturing edge it pushes the expected count and pin level into a queue. The monitor pops that item at the following falling edge, which is exactly one register stage later, and compares it there.

// File: rtl/dcpwm_pkg.sv
package dcpwm_pkg;

    // Byte select on the write port; the low bit picks low/high byte,
    // the high bit picks the compare channel.
    typedef enum logic [1:0] {
        ADDR_PULSE_HI  = 2'd0,
        ADDR_PULSE_LO  = 2'd1,
        ADDR_PERIOD_HI = 2'd2,
        ADDR_PERIOD_LO = 2'd3
    } reg_addr_e;

    localparam int N_CMP      = 2;
    localparam int CH_PULSE   = 0;
    localparam int CH_PERIOD  = 1;

endpackage

// File: rtl/dcpwm_decode.sv
module dcpwm_decode
    import dcpwm_pkg::*;
(
    input  logic             wr_en_i,
    input  logic [1:0]       wr_addr_i,
    output logic [N_CMP-1:0] wr_hi_o,
    output logic [N_CMP-1:0] wr_lo_o
);

    always_comb begin
        wr_hi_o = '0;
        wr_lo_o = '0;
        if (wr_en_i) begin
            unique case (reg_addr_e'(wr_addr_i))
                ADDR_PULSE_HI:  wr_hi_o[CH_PULSE]  = 1'b1;
                ADDR_PULSE_LO:  wr_lo_o[CH_PULSE]  = 1'b1;
                ADDR_PERIOD_HI: wr_hi_o[CH_PERIOD] = 1'b1;
                ADDR_PERIOD_LO: wr_lo_o[CH_PERIOD] = 1'b1;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/dcpwm_stage.sv
module dcpwm_stage #(
    parameter int BYTE_W = 8
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  wr_hi_i,
    input  logic                  wr_lo_i,
    input  logic [BYTE_W-1:0]     wr_data_i,
    input  logic                  load_i,
    output logic [2*BYTE_W-1:0]   shadow_o,
    output logic                  locked_o
);

    localparam int VAL_W = 2 * BYTE_W;

    typedef struct packed {
        logic [VAL_W-1:0] stage;
        logic [VAL_W-1:0] shadow;
        logic             lock;
    } stage_t;

    stage_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // Period-end transfer uses the values held before this edge.
        if (load_i && !st_q.lock) begin
            st_d.shadow = st_q.stage;
        end
        if (wr_hi_i) begin
            st_d.stage[VAL_W-1:BYTE_W] = wr_data_i;
            st_d.lock                  = 1'b1;
        end
        if (wr_lo_i) begin
            st_d.stage[BYTE_W-1:0] = wr_data_i;
            st_d.lock              = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign shadow_o = st_q.shadow;
    assign locked_o = st_q.lock;

endmodule

// File: rtl/dcpwm_core.sv
module dcpwm_core #(
    parameter int               CNT_W  = 16,
    parameter logic [CNT_W-1:0] RELOAD = 16'hFFFC
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             tick_i,
    input  logic             active_i,
    input  logic [CNT_W-1:0] pulse_cmp_i,
    input  logic [CNT_W-1:0] period_cmp_i,
    input  logic             lvl_pulse_i,
    input  logic             lvl_period_i,
    output logic [CNT_W-1:0] count_o,
    output logic             pin_o,
    output logic             period_end_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             pin;
    } core_t;

    core_t cr_d, cr_q;
    logic  hit_period, hit_pulse;

    always_comb begin
        hit_period = tick_i && active_i && (cr_q.cnt == period_cmp_i);
        hit_pulse  = tick_i && active_i && (cr_q.cnt == pulse_cmp_i);

        cr_d = cr_q;
        if (tick_i) begin
            cr_d.cnt = cr_q.cnt + CNT_W'(1);
        end
        if (hit_period) begin
            cr_d.cnt = RELOAD;
        end

        if (!active_i) begin
            cr_d.pin = 1'b0;
        end else if (hit_period) begin
            cr_d.pin = lvl_period_i;
        end else if (hit_pulse) begin
            cr_d.pin = lvl_pulse_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cr_q.cnt <= RELOAD;
            cr_q.pin <= 1'b0;
        end else begin
            cr_q <= cr_d;
        end
    end

    assign count_o      = cr_q.cnt;
    assign pin_o        = cr_q.pin;
    assign period_end_o = hit_period;

endmodule

// File: rtl/dcpwm_timer.sv
module dcpwm_timer
    import dcpwm_pkg::*;
#(
    parameter int BYTE_W      = 8,
    parameter int RELOAD_BACK = 4
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                tick_i,
    input  logic                wr_en_i,
    input  logic [1:0]          wr_addr_i,
    input  logic [BYTE_W-1:0]   wr_data_i,
    input  logic                pwm_en_i,
    input  logic                out_en_i,
    input  logic                lvl_pulse_i,
    input  logic                lvl_period_i,
    output logic [2*BYTE_W-1:0] count_o,
    output logic                pwm_o
);

    localparam int               CNT_W  = 2 * BYTE_W;
    localparam logic [CNT_W-1:0] RELOAD = CNT_W'(0) - CNT_W'(RELOAD_BACK);

    logic [N_CMP-1:0] wr_hi, wr_lo, locked;
    logic [CNT_W-1:0] shadow [N_CMP];
    logic [CNT_W-1:0] pulse_shd, period_shd;
    logic             period_end;
    logic             active;

    assign active = pwm_en_i && out_en_i;

    dcpwm_decode u_dec (
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_hi_o   (wr_hi),
        .wr_lo_o   (wr_lo)
    );

    for (genvar ch = 0; ch < N_CMP; ch++) begin : g_cmp
        dcpwm_stage #(.BYTE_W(BYTE_W)) u_stage (
            .clk_i     (clk_i),
            .rst_ni    (rst_ni),
            .wr_hi_i   (wr_hi[ch]),
            .wr_lo_i   (wr_lo[ch]),
            .wr_data_i (wr_data_i),
            .load_i    (period_end),
            .shadow_o  (shadow[ch]),
            .locked_o  (locked[ch])
        );
    end

    assign pulse_shd  = shadow[CH_PULSE];
    assign period_shd = shadow[CH_PERIOD];

    dcpwm_core #(.CNT_W(CNT_W), .RELOAD(RELOAD)) u_core (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .tick_i       (tick_i),
        .active_i     (active),
        .pulse_cmp_i  (pulse_shd),
        .period_cmp_i (period_shd),
        .lvl_pulse_i  (lvl_pulse_i),
        .lvl_period_i (lvl_period_i),
        .count_o      (count_o),
        .pin_o        (pwm_o),
        .period_end_o (period_end)
    );

endmodule

// File: rtl/dcpwm_chk.sv
module dcpwm_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             tick_i,
    input logic             pwm_en_i,
    input logic             out_en_i,
    input logic             lvl_pulse_i,
    input logic             lvl_period_i,
    input logic [CNT_W-1:0] count_o,
    input logic             pwm_o,
    input logic             period_end,
    input logic [CNT_W-1:0] pulse_shd,
    input logic [CNT_W-1:0] period_shd,
    input logic [1:0]       locked
);

    localparam logic [CNT_W-1:0] RELOAD_V = CNT_W'(0) - CNT_W'(4);

    a_r2_hold_without_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !tick_i |=> $stable(count_o));

    a_r3_reload_at_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
        period_end |=> count_o == RELOAD_V);

    a_r5_period_level_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
        period_end |=> pwm_o == $past(lvl_period_i));

    a_r4_pulse_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_i && pwm_en_i && out_en_i && count_o == pulse_shd && count_o != period_shd)
        |=> (pwm_o == $past(lvl_pulse_i)) && (count_o == $past(count_o) + CNT_W'(1)));

    a_r6_shadow_only_at_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !period_end |=> $stable(pulse_shd) && $stable(period_shd));

    a_r7_locked_keeps_shadow: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (period_end && locked[1]) |=> $stable(period_shd));

    a_r8_idle_pin_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(pwm_en_i && out_en_i) |=> !pwm_o);

    a_r8_idle_free_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_i && !(pwm_en_i && out_en_i)) |=> count_o == $past(count_o) + CNT_W'(1));

endmodule

bind dcpwm_timer dcpwm_chk #(.CNT_W(CNT_W)) u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tick_i       (tick_i),
    .pwm_en_i     (pwm_en_i),
    .out_en_i     (out_en_i),
    .lvl_pulse_i  (lvl_pulse_i),
    .lvl_period_i (lvl_period_i),
    .count_o      (count_o),
    .pwm_o        (pwm_o),
    .period_end   (period_end),
    .pulse_shd    (pulse_shd),
    .period_shd   (period_shd),
    .locked       (locked)
);

// File: tb/sim_dcpwm_timer.sv
`timescale 1ns/100ps
module sim_dcpwm_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = 2'd0;
    logic [7:0]  wr_data = 8'd0;
    logic        pwm_en = 1'b0;
    logic        out_en = 1'b0;
    logic        lvl_a = 1'b0;
    logic        lvl_b = 1'b0;
    logic [15:0] count;
    logic        pwm;

    always #2.5 clk = ~clk;

    dcpwm_timer u0 (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .tick_i       (tick),
        .wr_en_i      (wr_en),
        .wr_addr_i    (wr_addr),
        .wr_data_i    (wr_data),
        .pwm_en_i     (pwm_en),
        .out_en_i     (out_en),
        .lvl_pulse_i  (lvl_a),
        .lvl_period_i (lvl_b),
        .count_o      (count),
        .pwm_o        (pwm)
    );

    typedef struct {
        logic [15:0] cnt;
        logic        pin;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 1'b0;

    // Requirement-level model state
    logic [15:0] m_cnt = 16'hFFFC;
    logic        m_pin = 1'b0;
    logic [15:0] m_sa = 16'h0, m_sb = 16'h0;
    logic [15:0] m_ga = 16'h0, m_gb = 16'h0;
    logic        m_la = 1'b0, m_lb = 1'b0;

    task automatic check(input string tag, input string what,
                         input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s got %h expected %h", tag, what, got, exp);
        end
    endtask

    // Monitor: one register stage after capture, at the falling edge.
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            check(e.tag, "count", count, e.cnt);
            check(e.tag, "pwm", {15'd0, pwm}, {15'd0, e.pin});
        end
    end

    task automatic step(input logic tk, input logic we, input logic [1:0] ad,
                        input logic [7:0] dt, input string tag);
        logic        act, hb, ha;
        logic [15:0] n_cnt;
        logic        n_pin;
        exp_t        e;
        tick = tk; wr_en = we; wr_addr = ad; wr_data = dt;
        @(posedge clk);
        act   = pwm_en && out_en;
        hb    = tk && act && (m_cnt == m_sb);
        ha    = tk && act && (m_cnt == m_sa);
        n_cnt = tk ? m_cnt + 16'd1 : m_cnt;
        if (hb) n_cnt = 16'hFFFC;
        n_pin = m_pin;
        if (!act) n_pin = 1'b0;
        else if (hb) n_pin = lvl_b;
        else if (ha) n_pin = lvl_a;
        if (hb) begin
            if (!m_la) m_sa = m_ga;
            if (!m_lb) m_sb = m_gb;
        end
        if (we) begin
            case (ad)
                2'd0: begin m_ga[15:8] = dt; m_la = 1'b1; end
                2'd1: begin m_ga[7:0]  = dt; m_la = 1'b0; end
                2'd2: begin m_gb[15:8] = dt; m_lb = 1'b1; end
                default: begin m_gb[7:0] = dt; m_lb = 1'b0; end
            endcase
        end
        m_cnt = n_cnt;
        m_pin = n_pin;
        e.cnt = m_cnt; e.pin = m_pin; e.tag = tag;
        exp_q.push_back(e);
        #2;
        tick = 1'b0; wr_en = 1'b0;
    endtask

    task automatic run(input int n, input string tag);
        for (int i = 0; i < n; i++) step(1'b1, 1'b0, 2'd0, 8'd0, tag);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 100000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired, got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        check("R1", "reset count", count, 16'hFFFC);
        check("R1", "reset pwm", {15'd0, pwm}, 16'd0);
        @(posedge clk); #2;

        // R6: stage values with no tick; R2 count must hold
        step(1'b0, 1'b1, 2'd0, 8'h00, "R6");
        step(1'b0, 1'b1, 2'd1, 8'h06, "R6");
        step(1'b0, 1'b1, 2'd2, 8'h00, "R6");
        step(1'b0, 1'b1, 2'd3, 8'h0A, "R2");

        // R5: zero shadows match together at count 0, period action wins
        pwm_en = 1'b1; out_en = 1'b1; lvl_a = 1'b0; lvl_b = 1'b1;
        run(5, "R5");

        // R8: leave PWM mode at 0xFFFC, wrap through 0xFFFF, no reload
        pwm_en = 1'b0;
        run(6, "R8");
        pwm_en = 1'b1;

        // R3 / R4: periods with the loaded shadows
        run(12, "R3");
        run(30, "R4");

        // R2: ticks with gaps
        for (int i = 0; i < 30; i++) step(i[0], 1'b0, 2'd0, 8'd0, "R2");

        // R6: new pulse value mid-period takes effect only after period end
        run(4, "R6");
        step(1'b0, 1'b1, 2'd1, 8'h03, "R6");
        run(35, "R6");

        // R7: high byte alone locks period transfer
        step(1'b0, 1'b1, 2'd2, 8'h01, "R7");
        run(40, "R7");
        step(1'b0, 1'b1, 2'd3, 8'h05, "R7");
        run(300, "R7");
        step(1'b0, 1'b1, 2'd2, 8'h00, "R7");
        step(1'b0, 1'b1, 2'd3, 8'h08, "R7");
        run(300, "R7");

        // R4: swapped levels
        lvl_a = 1'b1; lvl_b = 1'b0;
        run(40, "R4");

        // R8: output enable off
        out_en = 1'b0;
        run(20, "R8");

        @(negedge clk); @(negedge clk);
        finish_run();
    end

endmodule